// File: doc/BRIEF.md
# Windowed watchdog timer

This block is a watchdog that counts a slow tick (nominally about 1 kHz) delivered as a single-cycle enable pulse in the system clock domain. Software has to clear it at the right moments, or the block raises its watchdog reset output. It has two modes. In normal mode, a reset is raised if no clear arrives within one configured period. In window mode, each cycle of the watchdog starts with a closed period, in which a clear counts as a fault and forces an immediate reset. An open period follows, in which a clear is accepted and the sequence starts again.

Two period codes sit in an 8-bit configuration register. Each code selects a power-of-two number of ticks. The register is preset from a boot configuration input while reset is active. A separate 3-bit control register turns the watchdog on, selects the mode, and holds an always-on flag. Once that flag is set, the configuration is frozen and the watchdog cannot be stopped until the next reset.

Top module: `wwdt_top`

## Requirements
- R1: While `rst_n` is low the configuration register takes `boot_cfg_i`, except that a reserved code (12 to 15) in either field loads as 11. The control register clears to 0, and `wdt_rst_o` and `early_fault_o` are low.
- R2: A period code n stands for 8·2^n ticks, so code 0 is 8 ticks and code 11 is 16384 ticks. The counter advances only in cycles in which `tick_i` is high.
- R3: In normal mode (control bit 1 = 0), if the tick that completes the period selected by config bits 3:0 arrives with no clear, `wdt_rst_o` goes high on the next clock.
- R4: In normal mode, a clear restarts the period from zero.
- R5: In window mode (control bit 1 = 1), a closed window of the length coded in config bits 7:4 comes first. An open window of the length coded in bits 3:0 follows. If the open window runs out with no clear, `wdt_rst_o` is raised.
- R6: A clear during the closed window raises `wdt_rst_o` on the next clock, together with a one-cycle pulse on `early_fault_o`.
- R7: A clear during the open window restarts the closed window from a count of zero.
- R8: A configuration write leaves unchanged any field that carries a reserved code (12 to 15). A legal field in the same write is still taken.
- R9: Always-on (control bit 2) can only be cleared by reset. While it is set, configuration writes are ignored, control bit 0 reads as 1, and the watchdog keeps running.
- R10: Once raised, `wdt_rst_o` stays high until reset. After that, clears and ticks change nothing.
- R11: While the watchdog is disabled (control bits 0 and 2 both 0), it does not count and ignores clears. Enabling it starts a fresh period from zero.
- R12: A write with `wr_addr_i` = 0 targets the control register: bit 0 enables, bit 1 selects window mode, bit 2 sets always-on. A write with `wr_addr_i` = 1 targets the configuration register: bits 7:4 hold the closed-window code and bits 3:0 hold the normal or open-window code. A write takes effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; samples the boot configuration |
| tick_i | input | 1 | One-cycle enable pulse from the slow time base |
| clear_i | input | 1 | Software clear strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register select: 0 control, 1 configuration |
| wr_data_i | input | 8 | Write data |
| boot_cfg_i | input | 8 | Boot-time configuration value |
| wdt_rst_o | output | 1 | Watchdog reset request, sticky until reset |
| early_fault_o | output | 1 | One-cycle pulse on a clear in the closed window |
| cfg_o | output | 8 | Configuration register contents |
| ctrl_o | output | 3 | Control register contents {always-on, window, enable} |

## Verification
The embedded assertions check the per-cycle rules on every cycle: the reset output stays high once set, and an early-fault pulse never appears without it. A clear in the closed window fires on the next clock, the counter holds between ticks, a stored code is never reserved, and the always-on flag stays set and freezes the configuration. Some behaviour only the bench's scenarios can show, because it depends on exact window lengths counted over many ticks. This covers where each window ends for a given code, whether a clear lands in the open or the closed part, normal-mode expiry, and the effect of boot values and of ignored writes on later timing.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int CODE_W     = 4;
  localparam int NUM_FIELDS = 2;
  localparam int CFG_W      = CODE_W * NUM_FIELDS;
  localparam int MAX_CODE   = 11;
  localparam int BASE_SHIFT = 3;

  // register select values
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CFG  = 1'b1;

  // control bit positions
  localparam int BIT_EN  = 0;
  localparam int BIT_WIN = 1;
  localparam int BIT_AON = 2;

  // field index inside the configuration register
  localparam int FLD_OPEN   = 0;
  localparam int FLD_CLOSED = 1;

  typedef struct packed {
    logic aon;
    logic win;
    logic en;
  } ctrl_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CLOSED = 2'd1,
    PH_OPEN   = 2'd2,
    PH_FIRED  = 2'd3
  } phase_e;
endpackage

// File: rtl/wwdt_regs.sv
module wwdt_regs
  import wwdt_pkg::*;
#(
  parameter int MAX_C = MAX_CODE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic [CFG_W-1:0] boot_cfg_i,
  output ctrl_t            ctrl_q,
  output logic [CFG_W-1:0] cfg_q
);

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return c <= CODE_W'(MAX_C);
  endfunction

  function automatic logic [CODE_W-1:0] boot_fix(input logic [CODE_W-1:0] c);
    return code_ok(c) ? c : CODE_W'(MAX_C);
  endfunction

  // named write events
  logic ctl_wr, cfg_wr_req, cfg_wr;
  assign ctl_wr     = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign cfg_wr_req = wr_en_i && (wr_addr_i == ADDR_CFG);
  assign cfg_wr     = cfg_wr_req && !ctrl_q.aon;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctl_wr) begin
      ctrl_q.aon <= ctrl_q.aon | wr_data_i[BIT_AON];
      ctrl_q.win <= wr_data_i[BIT_WIN];
      ctrl_q.en  <= wr_data_i[BIT_EN] | wr_data_i[BIT_AON] | ctrl_q.aon;
    end
  end

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    logic [CODE_W-1:0] fld_q, wr_f, boot_f;
    logic              take;
    assign wr_f   = wr_data_i[f*CODE_W +: CODE_W];
    assign boot_f = boot_cfg_i[f*CODE_W +: CODE_W];
    assign take   = cfg_wr && code_ok(wr_f);

    always_ff @(posedge clk) begin
      if (!rst_n)    fld_q <= boot_fix(boot_f);
      else if (take) fld_q <= wr_f;
    end

    assign cfg_q[f*CODE_W +: CODE_W] = fld_q;

    // R8: no reserved code is ever stored
    a_r8_field_legal: assert property (@(posedge clk) disable iff (!rst_n)
      code_ok(fld_q));
  end

  // R9: always-on is sticky until reset
  a_r9_aon_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.aon |=> ctrl_q.aon);

  // R9: configuration frozen while always-on
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.aon |=> $stable(cfg_q));

  // R9: enable reads as set while always-on
  a_r9_en_forced: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.aon) |-> ctrl_q.en);

endmodule

// File: rtl/wwdt_period.sv
module wwdt_period
  import wwdt_pkg::*;
#(
  parameter int SHIFT = BASE_SHIFT,
  parameter int CNT_W = BASE_SHIFT + MAX_CODE + 1
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  ticks_o
);
  // 2^(code+SHIFT) ticks
  function automatic logic [CNT_W-1:0] period_ticks(input logic [CODE_W-1:0] c);
    return CNT_W'(1) << (32'(c) + SHIFT);
  endfunction

  assign ticks_o = period_ticks(code_i);
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
  import wwdt_pkg::*;
#(
  parameter int SHIFT = BASE_SHIFT,
  parameter int CNT_W = BASE_SHIFT + MAX_CODE + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clear_i,
  input  ctrl_t            ctrl_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             wdt_rst_o,
  output logic             early_o
);

  phase_e            ph_q, ph_d, start_ph;
  logic [CNT_W-1:0]  cnt_q, cnt_d, limit;
  logic [CODE_W-1:0] code_sel;
  logic              early_q;

  // named internal events
  logic run_en, active, last_tick;
  logic ev_bad_clr, ev_good_clr, ev_closed_done, ev_open_done, ev_fire;

  assign run_en   = ctrl_i.en | ctrl_i.aon;
  assign active   = (ph_q == PH_CLOSED) || (ph_q == PH_OPEN);
  assign start_ph = ctrl_i.win ? PH_CLOSED : PH_OPEN;
  assign code_sel = (ph_q == PH_CLOSED) ? cfg_i[FLD_CLOSED*CODE_W +: CODE_W]
                                        : cfg_i[FLD_OPEN*CODE_W +: CODE_W];

  wwdt_period #(.SHIFT(SHIFT), .CNT_W(CNT_W)) u_period (
    .code_i (code_sel),
    .ticks_o(limit)
  );

  assign last_tick      = tick_i && (cnt_q >= limit - CNT_W'(1));
  assign ev_bad_clr     = active && run_en && clear_i && (ph_q == PH_CLOSED);
  assign ev_good_clr    = active && run_en && clear_i && (ph_q == PH_OPEN);
  assign ev_closed_done = active && run_en && !clear_i && last_tick && (ph_q == PH_CLOSED);
  assign ev_open_done   = active && run_en && !clear_i && last_tick && (ph_q == PH_OPEN);
  assign ev_fire        = ev_bad_clr || ev_open_done;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (run_en) begin
          ph_d  = start_ph;
          cnt_d = '0;
        end
      end
      PH_FIRED: begin
        ph_d = PH_FIRED;
      end
      default: begin
        if (!run_en) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end else if (ev_fire) begin
          ph_d = PH_FIRED;
        end else if (ev_good_clr) begin
          ph_d  = start_ph;
          cnt_d = '0;
        end else if (ev_closed_done) begin
          ph_d  = PH_OPEN;
          cnt_d = '0;
        end else if (tick_i) begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      early_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      early_q <= ev_bad_clr;
    end
  end

  assign wdt_rst_o = (ph_q == PH_FIRED);
  assign early_o   = early_q;

  // R10: reset request is sticky
  a_r10_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |=> wdt_rst_o);

  // R6: early fault never without reset request
  a_r6_early_has_rst: assert property (@(posedge clk) disable iff (!rst_n)
    early_o |-> wdt_rst_o);

  // R6: closed-window clear fires on the next clock
  a_r6_closed_clear_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_CLOSED) && run_en && clear_i |=> wdt_rst_o && early_o);

  // R2: no tick, no clear, still enabled: counter holds
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    active && run_en && !tick_i && !clear_i |=> $stable(cnt_q));

  // R11: idle means a zero count and no request
  a_r11_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE) |-> (cnt_q == '0) && !early_o);

endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
  import wwdt_pkg::*;
#(
  parameter int SHIFT = BASE_SHIFT,
  parameter int MAX_C = MAX_CODE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic [CFG_W-1:0] boot_cfg_i,
  output logic             wdt_rst_o,
  output logic             early_fault_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic [2:0]       ctrl_o
);
  localparam int CNT_W = SHIFT + MAX_C + 1;

  ctrl_t            ctrl_q;
  logic [CFG_W-1:0] cfg_q;

  wwdt_regs #(.MAX_C(MAX_C)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .boot_cfg_i(boot_cfg_i),
    .ctrl_q    (ctrl_q),
    .cfg_q     (cfg_q)
  );

  wwdt_core #(.SHIFT(SHIFT), .CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .clear_i  (clear_i),
    .ctrl_i   (ctrl_q),
    .cfg_i    (cfg_q),
    .wdt_rst_o(wdt_rst_o),
    .early_o  (early_fault_o)
  );

  assign cfg_o  = cfg_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: tb/wwdt_top_bench.sv
module wwdt_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, clear = 1'b0, wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00, boot = 8'h10;
  logic       wdt_rst, early;
  logic [7:0] cfg;
  logic [2:0] ctrl;

  int checks = 0, fails = 0, cycles = 0;
  bit tick_on = 1'b1, started = 1'b0;
  int div = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  wwdt_top u_wwdt_top (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .clear_i(clear),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .boot_cfg_i(boot), .wdt_rst_o(wdt_rst), .early_fault_o(early),
    .cfg_o(cfg), .ctrl_o(ctrl)
  );

  // ---------------- reference model ----------------
  int m_cc, m_co, m_ph, m_cnt, lim;   // ph: 0 off, 1 closed, 2 open, 3 fired
  bit m_en, m_win, m_aon, m_rst, m_early, run, old_aon;

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_cc = (boot[7:4] > 11) ? 11 : int'(boot[7:4]);
      m_co = (boot[3:0] > 11) ? 11 : int'(boot[3:0]);
      m_en = 0; m_win = 0; m_aon = 0;
      m_ph = 0; m_cnt = 0; m_rst = 0; m_early = 0;
    end else begin
      run = m_en || m_aon;
      m_early = 0;
      if (m_ph == 1 || m_ph == 2) begin
        if (!run) begin m_ph = 0; m_cnt = 0; end
        else if (clear) begin
          if (m_ph == 1) begin m_ph = 3; m_rst = 1; m_early = 1; end
          else begin m_ph = m_win ? 1 : 2; m_cnt = 0; end
        end else if (tick) begin
          lim = 8 * (2 ** ((m_ph == 1) ? m_cc : m_co));
          if (m_cnt + 1 >= lim) begin
            if (m_ph == 1) begin m_ph = 2; m_cnt = 0; end
            else begin m_ph = 3; m_rst = 1; end
          end else m_cnt = m_cnt + 1;
        end
      end else if (m_ph == 0 && run) begin
        m_ph = m_win ? 1 : 2; m_cnt = 0;
      end
      if (wr_en) begin
        if (!wr_addr) begin
          old_aon = m_aon;
          m_aon = m_aon | wr_data[2];
          m_win = wr_data[1];
          m_en  = wr_data[0] | wr_data[2] | old_aon;
        end else if (!m_aon) begin
          if (wr_data[7:4] <= 11) m_cc = int'(wr_data[7:4]);
          if (wr_data[3:0] <= 11) m_co = int'(wr_data[3:0]);
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare against the model on every cycle, away from the edge
  always @(negedge clk) begin
    if (started) begin
      chk(cur_req, int'(wdt_rst), int'(m_rst), "wdt_rst_o vs model");
      chk(cur_req, int'(early), int'(m_early), "early_fault_o vs model");
      chk(cur_req, int'(cfg), m_cc * 16 + m_co, "cfg_o vs model");
      chk(cur_req, int'(ctrl), int'({m_aon, m_win, m_en}), "ctrl_o vs model");
    end
  end

  // slow tick generator
  always @(posedge clk) begin
    #1;
    div  = (div + 1) % TICK_DIV;
    tick = tick_on && (div == 0);
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [7:0] b);
    @(posedge clk); #1;
    boot = b; rst_n = 0;
    wait_cyc(3);
    rst_n = 1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic pulse_clear();
    @(posedge clk); #1;
    clear = 1;
    @(posedge clk); #1;
    clear = 0;
  endtask

  initial begin
    // R1: boot value with a reserved upper field
    cur_req = "R1";
    do_reset(8'hF1);
    @(negedge clk);
    chk("R1", int'(cfg), 'hB1, "boot reserved field loads 11");
    chk("R1", int'(ctrl), 0, "control clear");
    chk("R1", int'(wdt_rst), 0, "no reset request");

    // R12 / R3 / R4: normal mode, 8-tick period
    cur_req = "R4";
    do_reset(8'h10);
    wr(1'b0, 8'h01);
    @(negedge clk);
    chk("R12", int'(ctrl), 1, "enable bit 0");
    for (int k = 0; k < 6; k++) begin wait_cyc(20); pulse_clear(); end
    @(negedge clk);
    chk("R4", int'(wdt_rst), 0, "periodic clears keep it alive");
    cur_req = "R3";
    wait_cyc(60);
    @(negedge clk);
    chk("R3", int'(wdt_rst), 1, "expiry without clear");
    cur_req = "R10";
    pulse_clear();
    wait_cyc(40);
    @(negedge clk);
    chk("R10", int'(wdt_rst), 1, "reset request sticky");

    // R2: code 2 = 32 ticks, and no counting without ticks
    cur_req = "R2";
    do_reset(8'h02);
    wr(1'b0, 8'h01);
    wait_cyc(100);
    @(negedge clk);
    chk("R2", int'(wdt_rst), 0, "32-tick period not yet over");
    wait_cyc(40);
    @(negedge clk);
    chk("R2", int'(wdt_rst), 1, "32-tick period over");
    do_reset(8'h10);
    tick_on = 0;
    wr(1'b0, 8'h01);
    wait_cyc(300);
    @(negedge clk);
    chk("R2", int'(wdt_rst), 0, "no ticks, no expiry");
    tick_on = 1;

    // R8: reserved field in a write is dropped, legal field taken
    cur_req = "R8";
    do_reset(8'h10);
    wr(1'b1, 8'hC3);
    @(negedge clk);
    chk("R8", int'(cfg), 'h13, "reserved closed code ignored");
    wr(1'b1, 8'h2E);
    @(negedge clk);
    chk("R8", int'(cfg), 'h23, "reserved open code ignored");

    // R6: clear in closed window
    cur_req = "R6";
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h03);
    @(negedge clk);
    chk("R12", int'(ctrl), 3, "window bit 1");
    wait_cyc(5);
    @(posedge clk); #1; clear = 1;
    @(negedge clk);
    chk("R6", int'(early), 0, "no fault before edge");
    @(posedge clk); #1; clear = 0;
    @(negedge clk);
    chk("R6", int'(early), 1, "early fault pulse");
    chk("R6", int'(wdt_rst), 1, "reset on closed clear");
    @(negedge clk);
    chk("R6", int'(early), 0, "pulse one cycle");

    // R7 / R5: window mode 8 closed + 8 open
    cur_req = "R7";
    do_reset(8'h00);
    wr(1'b0, 8'h03);
    for (int k = 0; k < 4; k++) begin wait_cyc(40); pulse_clear(); end
    @(negedge clk);
    chk("R7", int'(wdt_rst), 0, "open-window clears accepted");
    cur_req = "R5";
    wait_cyc(100);
    @(negedge clk);
    chk("R5", int'(wdt_rst), 1, "open window expiry");
    chk("R5", int'(early), 0, "expiry is no early fault");

    // R9: always-on
    cur_req = "R9";
    do_reset(8'h10);
    wr(1'b0, 8'h04);
    @(negedge clk);
    chk("R9", int'(ctrl), 5, "always-on forces enable");
    wr(1'b1, 8'h55);
    @(negedge clk);
    chk("R9", int'(cfg), 'h10, "config write ignored");
    wr(1'b0, 8'h00);
    @(negedge clk);
    chk("R9", int'(ctrl), 5, "always-on sticky");
    wait_cyc(60);
    @(negedge clk);
    chk("R9", int'(wdt_rst), 1, "still running");

    // R11: disabled
    cur_req = "R11";
    do_reset(8'h00);
    wr(1'b0, 8'h02);
    wait_cyc(50);
    pulse_clear();
    wait_cyc(150);
    @(negedge clk);
    chk("R11", int'(wdt_rst), 0, "disabled: no count, clear ignored");
    wr(1'b0, 8'h03);
    wait_cyc(20);
    @(negedge clk);
    chk("R11", int'(wdt_rst), 0, "enable starts fresh");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule